// File: doc/BRIEF.md
# Effective Address Generator

This block turns an addressing-mode code and the operand bytes of an 8-bit processor instruction into the 16-bit address the instruction will use. It takes the X and Y index values, the address of the first operand byte, and a branch-taken bit alongside the mode. The result comes with a page-crossing flag and the count of extra cycles the crossing or branch costs. Three modes have to read a 16-bit pointer from memory: the two indirect table modes and the indirect jump. For these the block issues two byte reads, low byte first, over a simple request/valid read port.

Requests arrive on a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. Back-pressure is simply `req_ready` staying low from that edge until the cycle after `ea_done`. While the block is busy, the request fields and `req_valid` have no effect. The result outputs keep their value until the next request is accepted.

Top module: `eag_top`

## Requirements
- R1: `req_ready` is 1 exactly in the idle cycles, that is after reset and from the cycle after `ea_done` until the next accept. A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. While the block is busy, the request inputs have no effect on any result.
- R2: `ea_done` is a single-cycle pulse. For modes that need no pointer, it comes in the cycle right after the accept edge. For pointer modes, it comes in the cycle after the second read's data cycle. `req_ready` returns in the cycle after `ea_done`.
- R3: Each read is one cycle of `mem_rd_req` with `mem_rd_addr`. The block waits any number of cycles for `mem_rd_valid` and takes `mem_rd_data` in that cycle. At most one read is outstanding. The low pointer byte is read first, and its request is issued in the cycle after the accept.
- R4: Mode code 0 (immediate) gives `ea_addr = req_pc`. Codes 11 to 15 act exactly like code 0.
- R5: Mode 1 (page zero) gives `{8'h00, op_lo}`. Mode 4 (absolute) gives `{op_hi, op_lo}`.
- R6: Modes 2 and 3 (page zero plus X or Y) give `{8'h00, (op_lo + index) mod 256}`. The address never leaves page zero.
- R7: Modes 5 and 6 (absolute plus X or Y) give `({op_hi,op_lo} + index) mod 65536`. `ea_page_cross` is 1 when the result's high byte differs from op_hi, and `ea_extra` equals that flag.
- R8: Mode 7 (X-indexed pointer) forms p = (op_lo + X) mod 256. It reads the low byte at `{8'h00,p}` and the high byte at `{8'h00,(p+1) mod 256}`, and the result is {high,low}.
- R9: Mode 8 (pointer then Y) reads the low byte at `{8'h00,op_lo}` and the high byte at `{8'h00,(op_lo+1) mod 256}`. The result is that base plus Y mod 65536. The page flag and `ea_extra` follow the same rule as R7, measured against the fetched base.
- R10: Mode 9 (indirect jump) reads the low byte at `{op_hi,op_lo}` and the high byte at `{op_hi,(op_lo+1) mod 256}`. When op_lo is 0xFF, the high byte comes from `{op_hi,8'h00}`.
- R11: Mode 10 (relative) gives (req_pc + 1 + sign-extended op_lo) mod 65536. `ea_page_cross` is set when the high byte differs from that of req_pc + 1. `ea_extra` is 0 when not taken, 1 when taken within the page, and 2 when taken across a page.
- R12: All modes other than 5, 6, 8 and 10 give `ea_page_cross = 0` and `ea_extra = 0`. The result outputs hold until the next accept. After reset, `ea_addr`, `ea_page_cross` and `ea_extra` are 0 and `mem_rd_req` and `ea_done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, high when idle |
| req_mode | input | 4 | Addressing-mode code |
| req_op_lo | input | 8 | First operand byte |
| req_op_hi | input | 8 | Second operand byte |
| req_idx_x | input | 8 | X index value |
| req_idx_y | input | 8 | Y index value |
| req_pc | input | 16 | Address of the first operand byte |
| req_br_taken | input | 1 | Branch condition is met (relative mode) |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_valid | input | 1 | Read data is present |
| mem_rd_data | input | 8 | Read data byte |
| ea_addr | output | 16 | Effective address |
| ea_page_cross | output | 1 | Indexed or branch result landed on another page |
| ea_extra | output | 2 | Extra cycles caused by the crossing or branch |
| ea_done | output | 1 | One-cycle pulse, result is final |

## Verification
A sequencer stuck in the wrong state shows up as an early or missing `ea_done`, or as a `req_ready` that is wrong in the very next cycle. A stray or doubled `mem_rd_req` is also visible at once. For that reason, the stream and read-port pins are compared against a reference on every clock. A wrong captured operand or a wrong pointer byte changes only `mem_rd_addr` on the next read request, or `ea_addr` in the `ea_done` cycle. The two page-wrap rules and the indirect-jump page bug therefore get their own stimuli at the 0xFF boundary. Memory latencies of one and three cycles are used, with garbage held on the request inputs while the block is busy.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM  = 4'd0,
    AM_ZP   = 4'd1,
    AM_ZPX  = 4'd2,
    AM_ZPY  = 4'd3,
    AM_ABS  = 4'd4,
    AM_ABSX = 4'd5,
    AM_ABSY = 4'd6,
    AM_INDX = 4'd7,
    AM_INDY = 4'd8,
    AM_JIND = 4'd9,
    AM_REL  = 4'd10
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0_REQ,
    ST_RD0_WAIT,
    ST_RD1_REQ,
    ST_RD1_WAIT,
    ST_DONE
  } seq_st_e;

  // Modes whose result depends on a two-byte pointer fetched from memory.
  function automatic logic needs_ptr(input logic [MODE_W-1:0] m);
    return (m == AM_INDX) || (m == AM_INDY) || (m == AM_JIND);
  endfunction

endpackage

// File: rtl/eag_index_add.sv
// Adds a zero-extended index to a two-byte base and flags a change of page.
module eag_index_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   idx,
  output logic [2*DW-1:0] sum,
  output logic            crossed
);
  localparam int AW = 2 * DW;

  assign sum     = base + {{(AW-DW){1'b0}}, idx};
  assign crossed = (sum[AW-1:DW] != base[AW-1:DW]);
endmodule

// File: rtl/eag_branch_calc.sv
// Relative target from the byte after the offset, with the branch cycle penalty.
module eag_branch_calc #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0]   offset,
  input  logic            taken,
  output logic [2*DW-1:0] target,
  output logic            crossed,
  output logic [1:0]      extra
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] next_pc;

  assign next_pc = pc + {{(AW-1){1'b0}}, 1'b1};
  assign target  = next_pc + {{(AW-DW){offset[DW-1]}}, offset};
  assign crossed = (target[AW-1:DW] != next_pc[AW-1:DW]);

  always_comb begin
    if (!taken)       extra = 2'd0;
    else if (crossed) extra = 2'd2;
    else              extra = 2'd1;
  end
endmodule

// File: rtl/eag_seq.sv
// Request acceptance and the two-byte pointer read sequence.
module eag_seq
  import eag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic ptr_mode,
  input  logic rd_valid,
  output logic req_ready,
  output logic accept,
  output logic rd_req,
  output logic rd_second,
  output logic cap_lo,
  output logic cap_hi,
  output logic done
);
  seq_st_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:     if (accept) st_nx = ptr_mode ? ST_RD0_REQ : ST_DONE;
      ST_RD0_REQ:  st_nx = ST_RD0_WAIT;
      ST_RD0_WAIT: if (rd_valid) st_nx = ST_RD1_REQ;
      ST_RD1_REQ:  st_nx = ST_RD1_WAIT;
      ST_RD1_WAIT: if (rd_valid) st_nx = ST_DONE;
      ST_DONE:     st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_req    = (st == ST_RD0_REQ) || (st == ST_RD1_REQ);
  assign rd_second = (st == ST_RD1_REQ) || (st == ST_RD1_WAIT);
  assign cap_lo    = (st == ST_RD0_WAIT) && rd_valid;
  assign cap_hi    = (st == ST_RD1_WAIT) && rd_valid;
  assign done      = (st == ST_DONE);

  // R2: completion is a single pulse and the stream reopens right after it
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  // R3: a read request lasts one cycle and is never back to back
  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R1: no new request is taken while a read is in flight
  assert_busy_during_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !req_ready);
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [DW-1:0]     req_op_lo,
  input  logic [DW-1:0]     req_op_hi,
  input  logic [DW-1:0]     req_idx_x,
  input  logic [DW-1:0]     req_idx_y,
  input  logic [2*DW-1:0]   req_pc,
  input  logic              req_br_taken,
  output logic              mem_rd_req,
  output logic [2*DW-1:0]   mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DW-1:0]     mem_rd_data,
  output logic [2*DW-1:0]   ea_addr,
  output logic              ea_page_cross,
  output logic [1:0]        ea_extra,
  output logic              ea_done
);
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] ZERO_PAGE = '0;
  localparam logic [DW-1:0] ONE_B     = {{(DW-1){1'b0}}, 1'b1};

  // ---------------- sequencer ----------------
  logic accept, rd_second, cap_lo, cap_hi;

  eag_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ptr_mode  (needs_ptr(req_mode)),
    .rd_valid  (mem_rd_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_req    (mem_rd_req),
    .rd_second (rd_second),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .done      (ea_done)
  );

  // ---------------- captured request and fetched pointer ----------------
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0]     lo_q, hi_q, x_q, y_q, ptr_lo_q, ptr_hi_q;
  logic [AW-1:0]     pc_q;
  logic              taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      x_q      <= '0;
      y_q      <= '0;
      pc_q     <= '0;
      taken_q  <= 1'b0;
      ptr_lo_q <= '0;
      ptr_hi_q <= '0;
    end else begin
      if (accept) begin
        mode_q  <= req_mode;
        lo_q    <= req_op_lo;
        hi_q    <= req_op_hi;
        x_q     <= req_idx_x;
        y_q     <= req_idx_y;
        pc_q    <= req_pc;
        taken_q <= req_br_taken;
      end
      if (cap_lo) ptr_lo_q <= mem_rd_data;
      if (cap_hi) ptr_hi_q <= mem_rd_data;
    end
  end

  // ---------------- arithmetic ----------------
  logic [DW-1:0] zp_x, zp_y, zp_x_nx, lo_nx;
  assign zp_x    = lo_q + x_q;      // wraps inside page zero
  assign zp_y    = lo_q + y_q;
  assign zp_x_nx = zp_x + ONE_B;
  assign lo_nx   = lo_q + ONE_B;    // pointer low byte wraps, page kept

  logic [AW-1:0] abs_sum, ind_sum, br_target;
  logic          abs_cross, ind_cross, br_cross;
  logic [1:0]    br_extra;

  eag_index_add #(.DW(DW)) u_abs_add (
    .base    ({hi_q, lo_q}),
    .idx     ((mode_q == AM_ABSY) ? y_q : x_q),
    .sum     (abs_sum),
    .crossed (abs_cross)
  );

  eag_index_add #(.DW(DW)) u_ind_add (
    .base    ({ptr_hi_q, ptr_lo_q}),
    .idx     (y_q),
    .sum     (ind_sum),
    .crossed (ind_cross)
  );

  eag_branch_calc #(.DW(DW)) u_branch (
    .pc      (pc_q),
    .offset  (lo_q),
    .taken   (taken_q),
    .target  (br_target),
    .crossed (br_cross),
    .extra   (br_extra)
  );

  // ---------------- pointer read addresses ----------------
  logic [AW-1:0] rd_addr_lo, rd_addr_hi;

  always_comb begin
    unique case (mode_q)
      AM_INDX: begin
        rd_addr_lo = {ZERO_PAGE, zp_x};
        rd_addr_hi = {ZERO_PAGE, zp_x_nx};
      end
      AM_INDY: begin
        rd_addr_lo = {ZERO_PAGE, lo_q};
        rd_addr_hi = {ZERO_PAGE, lo_nx};
      end
      default: begin
        rd_addr_lo = {hi_q, lo_q};
        rd_addr_hi = {hi_q, lo_nx};
      end
    endcase
  end

  assign mem_rd_addr = rd_second ? rd_addr_hi : rd_addr_lo;

  // ---------------- result selection ----------------
  always_comb begin
    ea_addr       = pc_q;
    ea_page_cross = 1'b0;
    ea_extra      = 2'd0;
    unique case (mode_q)
      AM_ZP:  ea_addr = {ZERO_PAGE, lo_q};
      AM_ZPX: ea_addr = {ZERO_PAGE, zp_x};
      AM_ZPY: ea_addr = {ZERO_PAGE, zp_y};
      AM_ABS: ea_addr = {hi_q, lo_q};
      AM_ABSX, AM_ABSY: begin
        ea_addr       = abs_sum;
        ea_page_cross = abs_cross;
        ea_extra      = {1'b0, abs_cross};
      end
      AM_INDX, AM_JIND: ea_addr = {ptr_hi_q, ptr_lo_q};
      AM_INDY: begin
        ea_addr       = ind_sum;
        ea_page_cross = ind_cross;
        ea_extra      = {1'b0, ind_cross};
      end
      AM_REL: begin
        ea_addr       = br_target;
        ea_page_cross = br_cross;
        ea_extra      = br_extra;
      end
      default: ea_addr = pc_q;
    endcase
  end

  // R8, R9: table pointer fetches stay inside page zero
  assert_ptr_page_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && ((mode_q == AM_INDX) || (mode_q == AM_INDY)))
      |-> (mem_rd_addr[AW-1:DW] == ZERO_PAGE));
  // R10: both jump pointer fetches come from the operand's own page
  assert_jind_same_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && (mode_q == AM_JIND)) |-> (mem_rd_addr[AW-1:DW] == hi_q));
  // R6: indexed page-zero results never leave page zero
  assert_zp_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_done && ((mode_q == AM_ZPX) || (mode_q == AM_ZPY)))
      |-> (ea_addr[AW-1:DW] == ZERO_PAGE));
  // R7: an indexed crossing costs exactly one cycle
  assert_abs_penalty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_done && ((mode_q == AM_ABSX) || (mode_q == AM_ABSY)))
      |-> (ea_extra == {1'b0, ea_page_cross}));
  // R11: an untaken branch costs nothing
  assert_untaken_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_done && (mode_q == AM_REL) && !taken_q) |-> (ea_extra == 2'd0));
  // R12: results hold while idle with nothing accepted
  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(ea_addr) && $stable(ea_extra)
                                   && $stable(ea_page_cross)));
endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        rdy;
    logic        rq;
    logic [15:0] ad;
    logic        dn;
  } cyc_t;

  bit          clk = 0;
  bit          rst_n = 0;
  bit          req_valid = 0;
  logic        req_ready;
  bit   [3:0]  req_mode = 0;
  bit   [7:0]  req_op_lo = 0, req_op_hi = 0, req_idx_x = 0, req_idx_y = 0;
  bit   [15:0] req_pc = 0;
  bit          req_br_taken = 0;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  bit          mem_rd_valid = 0;
  bit   [7:0]  mem_rd_data = 0;
  logic [15:0] ea_addr;
  logic        ea_page_cross;
  logic [1:0]  ea_extra;
  logic        ea_done;

  int n_checks = 0;
  int n_errors = 0;
  int lat = 1;
  int pend_cnt = 0;
  bit [15:0] pend_addr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eag_top dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op_lo(req_op_lo), .req_op_hi(req_op_hi),
    .req_idx_x(req_idx_x), .req_idx_y(req_idx_y), .req_pc(req_pc),
    .req_br_taken(req_br_taken),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .ea_addr(ea_addr), .ea_page_cross(ea_page_cross), .ea_extra(ea_extra),
    .ea_done(ea_done)
  );

  // Memory contents: a few fixed words for the jump cases, a formula elsewhere.
  function automatic bit [7:0] mem_byte(input bit [15:0] a);
    if (a == 16'h30FF) return 8'h80;
    if (a == 16'h3000) return 8'h40;
    if (a == 16'h3100) return 8'h50;
    return (a[7:0] ^ a[15:8]) + 8'h3C;
  endfunction

  // Read responder with latency lat (data in cycle req + lat).
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pend_cnt == 1) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem_byte(pend_addr);
    end
    if (pend_cnt > 0) pend_cnt <= pend_cnt - 1;
    if (mem_rd_req === 1'b1) begin
      if (lat <= 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_byte(mem_rd_addr);
      end else begin
        pend_cnt  <= lat - 1;
        pend_addr <= mem_rd_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic cyc_t mk(input bit rdy, input bit rq, input int ad, input bit dn);
    cyc_t c;
    c.rdy = rdy; c.rq = rq; c.ad = ad[15:0]; c.dn = dn;
    return c;
  endfunction

  task automatic run_op(input int mode, input int lo, input int hi, input int x,
                        input int y, input int pc, input bit tk, input int lat_i,
                        input bit noise, input string rq);
    cyc_t q[$];
    int ea_e, pcx_e, ext_e, a0, a1, b, nb, off;
    bit ptr;
    ea_e = pc; pcx_e = 0; ext_e = 0; a0 = 0; a1 = 0; ptr = 0;
    case (mode)
      1: ea_e = lo;
      2: ea_e = (lo + x) & 255;
      3: ea_e = (lo + y) & 255;
      4: ea_e = hi * 256 + lo;
      5, 6: begin
        b = hi * 256 + lo;
        ea_e = (b + ((mode == 5) ? x : y)) & 16'hFFFF;
        pcx_e = ((ea_e >> 8) != (b >> 8)) ? 1 : 0;
        ext_e = pcx_e;
      end
      7: begin
        ptr = 1; a0 = (lo + x) & 255; a1 = (a0 + 1) & 255;
        ea_e = mem_byte(a1[15:0]) * 256 + mem_byte(a0[15:0]);
      end
      8: begin
        ptr = 1; a0 = lo; a1 = (lo + 1) & 255;
        b = mem_byte(a1[15:0]) * 256 + mem_byte(a0[15:0]);
        ea_e = (b + y) & 16'hFFFF;
        pcx_e = ((ea_e >> 8) != (b >> 8)) ? 1 : 0;
        ext_e = pcx_e;
      end
      9: begin
        ptr = 1; a0 = hi * 256 + lo; a1 = hi * 256 + ((lo + 1) & 255);
        ea_e = mem_byte(a1[15:0]) * 256 + mem_byte(a0[15:0]);
      end
      10: begin
        nb = (pc + 1) & 16'hFFFF;
        off = (lo >= 128) ? lo - 256 : lo;
        ea_e = (nb + off) & 16'hFFFF;
        pcx_e = ((ea_e >> 8) != (nb >> 8)) ? 1 : 0;
        ext_e = tk ? (pcx_e ? 2 : 1) : 0;
      end
      default: ea_e = pc;
    endcase

    if (ptr) begin
      q.push_back(mk(0, 1, a0, 0));
      for (int i = 0; i < lat_i; i++) q.push_back(mk(0, 0, 0, 0));
      q.push_back(mk(0, 1, a1, 0));
      for (int i = 0; i < lat_i; i++) q.push_back(mk(0, 0, 0, 0));
    end
    q.push_back(mk(0, 0, 0, 1));
    q.push_back(mk(1, 0, 0, 0));

    lat = lat_i;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "ready before accept", req_ready, 1);
    req_valid = 1; req_mode = mode[3:0]; req_op_lo = lo[7:0]; req_op_hi = hi[7:0];
    req_idx_x = x[7:0]; req_idx_y = y[7:0]; req_pc = pc[15:0]; req_br_taken = tk;

    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      chk(req_ready === q[i].rdy, "R1", "req_ready", req_ready, q[i].rdy);
      chk(mem_rd_req === q[i].rq, "R3", "mem_rd_req", mem_rd_req, q[i].rq);
      if (q[i].rq)
        chk(mem_rd_addr === q[i].ad, "R3", "mem_rd_addr", mem_rd_addr, q[i].ad);
      chk(ea_done === q[i].dn, "R2", "ea_done", ea_done, q[i].dn);
      if (q[i].dn || q[i].rdy) begin
        chk(ea_addr === ea_e[15:0], q[i].dn ? rq : "R12", "ea_addr", ea_addr, ea_e);
        chk(ea_page_cross === pcx_e[0], q[i].dn ? rq : "R12", "ea_page_cross",
            ea_page_cross, pcx_e);
        chk(ea_extra === ext_e[1:0], q[i].dn ? rq : "R12", "ea_extra", ea_extra, ext_e);
      end
      req_valid = noise && !q[i].rdy;
      if (noise) begin
        req_mode = $urandom_range(0, 15);
        req_op_lo = $urandom; req_op_hi = $urandom;
        req_idx_x = $urandom; req_idx_y = $urandom;
        req_pc = $urandom; req_br_taken = $urandom;
      end
    end
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(req_ready === 1'b1, "R12", "reset req_ready", req_ready, 1);
    chk(mem_rd_req === 1'b0, "R12", "reset mem_rd_req", mem_rd_req, 0);
    chk(ea_done === 1'b0, "R12", "reset ea_done", ea_done, 0);
    chk(ea_addr === 16'h0, "R12", "reset ea_addr", ea_addr, 0);
    chk(ea_page_cross === 1'b0 && ea_extra === 2'd0, "R12", "reset flags",
        {ea_page_cross, ea_extra}, 0);
    rst_n = 1;
    @(negedge clk);

    run_op(0,  8'h55, 8'h66, 0, 0, 16'h1234, 0, 1, 0, "R4");
    run_op(13, 8'h55, 8'h66, 0, 0, 16'hBEEF, 1, 1, 0, "R4");
    run_op(1,  8'h42, 8'h99, 0, 0, 16'h0300, 0, 1, 0, "R5");
    run_op(4,  8'h34, 8'h12, 0, 0, 16'h0300, 0, 1, 1, "R5");
    run_op(2,  8'hF0, 8'h77, 8'h20, 0, 16'h0300, 0, 1, 0, "R6");
    run_op(3,  8'h10, 8'h77, 0, 8'h05, 16'h0300, 0, 1, 0, "R6");
    run_op(5,  8'hF0, 8'h12, 8'h20, 0, 16'h0300, 0, 1, 0, "R7");
    run_op(6,  8'h00, 8'h12, 0, 8'h05, 16'h0300, 0, 1, 0, "R7");
    run_op(5,  8'hF0, 8'hFF, 8'h20, 0, 16'h0300, 0, 1, 1, "R7");
    run_op(7,  8'hFE, 8'h00, 8'h01, 0, 16'h0300, 0, 1, 0, "R8");
    run_op(7,  8'h20, 8'h00, 8'h04, 0, 16'h0300, 0, 3, 1, "R8");
    run_op(8,  8'hFF, 8'h00, 0, 8'hFF, 16'h0300, 0, 1, 0, "R9");
    run_op(8,  8'h40, 8'h00, 0, 8'h01, 16'h0300, 0, 3, 1, "R9");
    run_op(9,  8'hFF, 8'h30, 0, 0, 16'h0300, 0, 1, 0, "R10");
    run_op(9,  8'h00, 8'h31, 0, 0, 16'h0300, 0, 3, 1, "R10");
    run_op(10, 8'h7F, 8'h00, 0, 0, 16'h10F0, 1, 1, 0, "R11");
    run_op(10, 8'h80, 8'h00, 0, 0, 16'h2000, 1, 1, 0, "R11");
    run_op(10, 8'h80, 8'h00, 0, 0, 16'h2000, 0, 1, 0, "R11");
    run_op(10, 8'h05, 8'h00, 0, 0, 16'h4010, 1, 1, 1, "R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule